// File: doc/BRIEF.md
# Windowed Display RAM Address Pointer

This block produces the page and column address for every data byte that is written into a monochrome display memory organised as 8 pages by 128 columns. A command decoder upstream drives strobes that set the traversal mode, load a rectangular window (column start/end and page start/end), or place the pointer directly. A separate access strobe marks each data byte. During the strobe cycle the block raises the memory write enable and presents the current address. On the following clock edge it moves the pointer according to the active mode.

Three traversal policies are supported. In page mode the column runs inside the column window and wraps without touching the page. In horizontal mode the column runs first and carries into the page. In vertical mode the page runs first and carries into the column. In horizontal and vertical mode the window behaves as a closed rectangle: after its last cell the pointer returns to its first cell. When a pointer is outside its window, it counts upward with natural wrap at the address maximum until it reaches the end address.

Top module: `addr_pointer_gen`

## Requirements
- R1: After synchronous reset the pointer is at page 0, column 0. The column window is 0..127, the page window is 0..7, and the mode is page mode.
- R2: In page mode (mode code 2'b10) each access advances the column by one. An access at the column end address sends the column to the column start address. The page never changes on an access.
- R3: In horizontal mode (mode code 2'b00) each access advances the column. An access at the column end sends the column to the column start and advances the page by one.
- R4: In vertical mode (mode code 2'b01) each access advances the page. An access at the page end sends the page to the page start and advances the column by one.
- R5: In horizontal or vertical mode, an access with both pointers at their end addresses returns both to their start addresses. Example: columns 2..125 and pages 1..6 in horizontal mode give a sequence (1,2)..(1,125), (2,2), ..., (6,125), (1,2).
- R6: A column window load stores start and end and places the column at the new start. A page window load does the same for the page.
- R7: Direct placement works as follows. A page select sets the page. A lower-nibble load sets column bits 3:0. An upper-nibble load sets column bits 6:4 from nibble bits 2:0. Page 2 with lower nibble 3 and upper nibble 0 gives column 3 of page 2.
- R8: mem_we equals the access strobe in the same cycle. The address outputs during that cycle are the pre-access address. The pointer moves on the next clock edge.
- R9: A mode strobe carrying the reserved code 2'b11 leaves the mode unchanged.
- R10: On one axis, a window load takes precedence over direct placement, and direct placement takes precedence over an access step.
- R11: Without any strobe, the pointer holds its value.
- R12: Stepping uses these rules: at the end address the pointer goes to the start address; otherwise it adds one, wrapping from the maximum address (127 or 7) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_set | input | 1 | Mode load strobe |
| mode_code | input | 2 | 00 horizontal, 01 vertical, 10 page, 11 reserved |
| col_win_load | input | 1 | Column window load strobe |
| col_lo_in | input | 7 | Column window start |
| col_hi_in | input | 7 | Column window end |
| page_win_load | input | 1 | Page window load strobe |
| page_lo_in | input | 3 | Page window start |
| page_hi_in | input | 3 | Page window end |
| page_sel_load | input | 1 | Direct page placement strobe |
| page_sel_in | input | 3 | Page value for direct placement |
| col_nlo_load | input | 1 | Load column bits 3:0 from nib_in |
| col_nhi_load | input | 1 | Load column bits 6:4 from nib_in[2:0] |
| nib_in | input | 4 | Column nibble value |
| acc | input | 1 | Data byte access strobe |
| cur_page | output | 3 | Current page address |
| cur_col | output | 7 | Current column address |
| mem_we | output | 1 | Memory write enable |

## Verification
The hardest case to reach from the ports is the simultaneous wrap of both axes in horizontal or vertical mode. It needs a full traversal of the window, so a bench driven only by random access strobes almost never gets there with a full-size window. Directed runs therefore load small windows, and the 2..125 by 1..6 example, then stream exactly enough accesses to cross every wrap. Random phases then mix window loads that have end below start, direct placement outside the window and same-cycle load/access collisions. These inputs exercise the natural wrap at the address maximum and the precedence rules.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [1:0] {
        AM_HORZ = 2'b00,
        AM_VERT = 2'b01,
        AM_PAGE = 2'b10
    } addr_mode_e;

    localparam logic [1:0] AM_RSVD = 2'b11;

    typedef struct packed {
        logic col_step;
        logic page_step;
    } step_t;

    // Reserved code keeps the current mode.
    function automatic addr_mode_e decode_mode(input logic [1:0] code,
                                               input addr_mode_e cur);
        if (code == AM_RSVD) begin
            return cur;
        end
        return addr_mode_e'(code);
    endfunction

    // Decide which axes advance on an access.
    function automatic step_t plan_step(input addr_mode_e m,
                                        input logic access,
                                        input logic col_at_end,
                                        input logic page_at_end);
        step_t s;
        s = '0;
        unique case (m)
            AM_HORZ: begin
                s.col_step  = access;
                s.page_step = access & col_at_end;
            end
            AM_VERT: begin
                s.page_step = access;
                s.col_step  = access & page_at_end;
            end
            default: begin
                s.col_step  = access;
                s.page_step = 1'b0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dpa_window.sv
module dpa_window #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] hi_in,
    output logic [W-1:0] start_o,
    output logic [W-1:0] end_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_o <= '0;
            end_o   <= '1;
        end else if (load) begin
            start_o <= lo_in;
            end_o   <= hi_in;
        end
    end
endmodule

// File: rtl/dpa_axis.sv
module dpa_axis #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] restart_val,
    input  logic         direct_load,
    input  logic [W-1:0] direct_val,
    input  logic         step,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] end_i,
    output logic [W-1:0] ptr_o,
    output logic         at_end_o
);
    logic [W-1:0] stepped;

    assign at_end_o = (ptr_o == end_i);
    assign stepped  = at_end_o ? start_i : W'(ptr_o + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o <= '0;
        end else if (restart) begin
            ptr_o <= restart_val;
        end else if (direct_load) begin
            ptr_o <= direct_val;
        end else if (step) begin
            ptr_o <= stepped;
        end
    end
endmodule

// File: rtl/addr_pointer_gen.sv
module addr_pointer_gen
    import dpa_pkg::*;
#(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 3,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_set,
    input  logic [1:0]        mode_code,
    input  logic              col_win_load,
    input  logic [COL_W-1:0]  col_lo_in,
    input  logic [COL_W-1:0]  col_hi_in,
    input  logic              page_win_load,
    input  logic [PAGE_W-1:0] page_lo_in,
    input  logic [PAGE_W-1:0] page_hi_in,
    input  logic              page_sel_load,
    input  logic [PAGE_W-1:0] page_sel_in,
    input  logic              col_nlo_load,
    input  logic              col_nhi_load,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic              acc,
    output logic [PAGE_W-1:0] cur_page,
    output logic [COL_W-1:0]  cur_col,
    output logic              mem_we
);
    localparam int HI_W = COL_W - NIB_W;

    addr_mode_e        mode_q;
    logic [COL_W-1:0]  col_start_w, col_end_w, col_direct;
    logic [PAGE_W-1:0] page_start_w, page_end_w;
    logic              col_at_end, page_at_end;
    step_t             stp;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= AM_PAGE;
        end else if (mode_set) begin
            mode_q <= decode_mode(mode_code, mode_q);
        end
    end

    assign stp = plan_step(mode_q, acc, col_at_end, page_at_end);

    // Assemble the column value from the nibble strobes.
    always_comb begin
        col_direct = cur_col;
        if (col_nlo_load) begin
            col_direct[NIB_W-1:0] = nib_in;
        end
        if (col_nhi_load) begin
            col_direct[COL_W-1:NIB_W] = nib_in[HI_W-1:0];
        end
    end

    dpa_window #(.W(COL_W)) u_col_win (
        .clk(clk), .rst(rst), .load(col_win_load),
        .lo_in(col_lo_in), .hi_in(col_hi_in),
        .start_o(col_start_w), .end_o(col_end_w)
    );

    dpa_window #(.W(PAGE_W)) u_page_win (
        .clk(clk), .rst(rst), .load(page_win_load),
        .lo_in(page_lo_in), .hi_in(page_hi_in),
        .start_o(page_start_w), .end_o(page_end_w)
    );

    dpa_axis #(.W(COL_W)) u_col_axis (
        .clk(clk), .rst(rst),
        .restart(col_win_load), .restart_val(col_lo_in),
        .direct_load(col_nlo_load | col_nhi_load), .direct_val(col_direct),
        .step(stp.col_step),
        .start_i(col_start_w), .end_i(col_end_w),
        .ptr_o(cur_col), .at_end_o(col_at_end)
    );

    dpa_axis #(.W(PAGE_W)) u_page_axis (
        .clk(clk), .rst(rst),
        .restart(page_win_load), .restart_val(page_lo_in),
        .direct_load(page_sel_load), .direct_val(page_sel_in),
        .step(stp.page_step),
        .start_i(page_start_w), .end_i(page_end_w),
        .ptr_o(cur_page), .at_end_o(page_at_end)
    );

    assign mem_we = acc;

endmodule

// File: rtl/dpa_checker.sv
module dpa_checker
    import dpa_pkg::*;
#(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input addr_mode_e        mode_q,
    input logic              acc,
    input logic              col_win_load,
    input logic              page_win_load,
    input logic              page_sel_load,
    input logic              col_nlo_load,
    input logic              col_nhi_load,
    input logic              mode_set,
    input logic [COL_W-1:0]  col_lo_in,
    input logic [PAGE_W-1:0] page_lo_in,
    input logic [COL_W-1:0]  col_end_w,
    input logic [PAGE_W-1:0] page_end_w,
    input logic [COL_W-1:0]  cur_col,
    input logic [PAGE_W-1:0] cur_page
);
    logic any_load;
    assign any_load = col_win_load | page_win_load | page_sel_load |
                      col_nlo_load | col_nhi_load;

    // R2: page never moves on a page-mode access
    a_r2_page_held: assert property (@(posedge clk) disable iff (rst)
        (mode_q == AM_PAGE && acc && !any_load) |=> $stable(cur_page));

    // R3: horizontal column advance away from the end
    a_r3_horz_col_inc: assert property (@(posedge clk) disable iff (rst)
        (mode_q == AM_HORZ && acc && !any_load && cur_col != col_end_w)
        |=> (cur_col == COL_W'($past(cur_col) + 1'b1)) && $stable(cur_page));

    // R4: vertical page advance away from the end
    a_r4_vert_page_inc: assert property (@(posedge clk) disable iff (rst)
        (mode_q == AM_VERT && acc && !any_load && cur_page != page_end_w)
        |=> (cur_page == PAGE_W'($past(cur_page) + 1'b1)) && $stable(cur_col));

    // R6: window loads restart the pointer
    a_r6_col_restart: assert property (@(posedge clk) disable iff (rst)
        col_win_load |=> cur_col == $past(col_lo_in));

    a_r6_page_restart: assert property (@(posedge clk) disable iff (rst)
        page_win_load |=> cur_page == $past(page_lo_in));

    // R11: idle cycles hold the pointer
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!acc && !any_load && !mode_set) |=> $stable(cur_col) && $stable(cur_page));

endmodule

bind addr_pointer_gen dpa_checker #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_dpa_checker (
    .clk(clk), .rst(rst), .mode_q(mode_q), .acc(acc),
    .col_win_load(col_win_load), .page_win_load(page_win_load),
    .page_sel_load(page_sel_load), .col_nlo_load(col_nlo_load),
    .col_nhi_load(col_nhi_load), .mode_set(mode_set),
    .col_lo_in(col_lo_in), .page_lo_in(page_lo_in),
    .col_end_w(col_end_w), .page_end_w(page_end_w),
    .cur_col(cur_col), .cur_page(cur_page)
);

// File: tb/test_addr_pointer_gen.sv
module test_addr_pointer_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_set;
    logic [1:0] mode_code;
    logic       col_win_load;
    logic [6:0] col_lo_in, col_hi_in;
    logic       page_win_load;
    logic [2:0] page_lo_in, page_hi_in;
    logic       page_sel_load;
    logic [2:0] page_sel_in;
    logic       col_nlo_load, col_nhi_load;
    logic [3:0] nib_in;
    logic       acc;
    logic [2:0] cur_page;
    logic [6:0] cur_col;
    logic       mem_we;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int m_col, m_page, m_cs, m_ce, m_ps, m_pe, m_mode;

    always #5 clk = ~clk;

    addr_pointer_gen i_addr_pointer_gen (
        .clk(clk), .rst(rst), .mode_set(mode_set), .mode_code(mode_code),
        .col_win_load(col_win_load), .col_lo_in(col_lo_in), .col_hi_in(col_hi_in),
        .page_win_load(page_win_load), .page_lo_in(page_lo_in), .page_hi_in(page_hi_in),
        .page_sel_load(page_sel_load), .page_sel_in(page_sel_in),
        .col_nlo_load(col_nlo_load), .col_nhi_load(col_nhi_load), .nib_in(nib_in),
        .acc(acc), .cur_page(cur_page), .cur_col(cur_col), .mem_we(mem_we)
    );

    function automatic int nxt(int p, int s, int e, int mx);
        if (p == e) return s;
        return (p == mx) ? 0 : p + 1;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        mode_set = 0; mode_code = 0; col_win_load = 0; col_lo_in = 0; col_hi_in = 0;
        page_win_load = 0; page_lo_in = 0; page_hi_in = 0; page_sel_load = 0;
        page_sel_in = 0; col_nlo_load = 0; col_nhi_load = 0; nib_in = 0; acc = 0;
    endtask

    // Inputs are already set just after a falling edge.
    task automatic run_cycle(string tag);
        int nc, np, cstep, pstep, v;
        #1;
        chk(mem_we == acc, "R8 mem_we", int'(mem_we), int'(acc));
        chk(int'(cur_col) == m_col, "R8 col before edge", int'(cur_col), m_col);
        cstep = 0; pstep = 0;
        if (acc) begin
            if (m_mode == 0) begin cstep = 1; pstep = (m_col == m_ce); end
            else if (m_mode == 1) begin pstep = 1; cstep = (m_page == m_pe); end
            else cstep = 1;
        end
        nc = m_col;
        if (col_win_load) nc = int'(col_lo_in);
        else if (col_nlo_load || col_nhi_load) begin
            v = m_col;
            if (col_nlo_load) v = (v & 'h70) | int'(nib_in);
            if (col_nhi_load) v = (v & 'h0f) | ((int'(nib_in) & 7) << 4);
            nc = v;
        end else if (cstep != 0) nc = nxt(m_col, m_cs, m_ce, 127);
        np = m_page;
        if (page_win_load) np = int'(page_lo_in);
        else if (page_sel_load) np = int'(page_sel_in);
        else if (pstep != 0) np = nxt(m_page, m_ps, m_pe, 7);
        if (col_win_load) begin m_cs = int'(col_lo_in); m_ce = int'(col_hi_in); end
        if (page_win_load) begin m_ps = int'(page_lo_in); m_pe = int'(page_hi_in); end
        if (mode_set && mode_code != 2'b11) m_mode = int'(mode_code);
        m_col = nc; m_page = np;
        @(posedge clk);
        @(negedge clk);
        chk(int'(cur_col) == m_col, {tag, " col"}, int'(cur_col), m_col);
        chk(int'(cur_page) == m_page, {tag, " page"}, int'(cur_page), m_page);
        clear_in();
    endtask

    task automatic accesses(int n, string tag);
        for (int i = 0; i < n; i++) begin
            acc = 1;
            run_cycle(tag);
        end
    endtask

    task automatic set_mode(int code, string tag);
        mode_set = 1; mode_code = 2'(code);
        run_cycle(tag);
    endtask

    task automatic set_windows(int cs, int ce, int ps, int pe, string tag);
        col_win_load = 1; col_lo_in = 7'(cs); col_hi_in = 7'(ce);
        page_win_load = 1; page_lo_in = 3'(ps); page_hi_in = 3'(pe);
        run_cycle(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        string tg;
        void'($urandom(32'd2718));
        clear_in();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_col = 0; m_page = 0; m_cs = 0; m_ce = 127; m_ps = 0; m_pe = 7; m_mode = 2;
        #1;
        chk(cur_col == 0, "R1 reset col", int'(cur_col), 0);
        chk(cur_page == 0, "R1 reset page", int'(cur_page), 0);
        chk(mem_we == 0, "R1 reset we", int'(mem_we), 0);
        @(negedge clk);

        // R1/R2: reset mode is page mode, full window wraps column only
        accesses(130, "R2");
        chk(cur_col == 2 && cur_page == 0, "R2 wrap", int'(cur_col), 2);

        // R7: direct placement example
        page_sel_load = 1; page_sel_in = 3'd2;
        col_nlo_load = 1; col_nhi_load = 1; nib_in = 4'd3;
        run_cycle("R7");
        col_nhi_load = 1; nib_in = 4'd0;
        run_cycle("R7");
        chk(cur_col == 3 && cur_page == 2, "R7 example", int'(cur_col), 3);
        col_nhi_load = 1; nib_in = 4'hd;
        run_cycle("R7");
        chk(cur_col == 7'h53, "R7 upper", int'(cur_col), 'h53);

        // R2/R12: pointer outside column window wraps through max
        col_win_load = 1; col_lo_in = 7'd10; col_hi_in = 7'd12;
        run_cycle("R6");
        col_nlo_load = 1; col_nhi_load = 1; nib_in = 4'hf;
        run_cycle("R7");
        accesses(20, "R12");

        // R10: collisions of load and access
        col_win_load = 1; col_lo_in = 7'd40; col_hi_in = 7'd50; acc = 1;
        run_cycle("R10");
        chk(cur_col == 40, "R10 win over step", int'(cur_col), 40);
        col_nlo_load = 1; nib_in = 4'd5; acc = 1;
        run_cycle("R10");
        col_win_load = 1; col_lo_in = 7'd60; col_hi_in = 7'd70; col_nlo_load = 1; nib_in = 4'd1;
        run_cycle("R10");
        chk(cur_col == 60, "R10 win over nibble", int'(cur_col), 60);

        // R3/R5: horizontal example window
        set_mode(0, "R3");
        set_windows(2, 125, 1, 6, "R6");
        chk(cur_col == 2 && cur_page == 1, "R6 restart", int'(cur_col), 2);
        accesses(123, "R3");
        chk(cur_col == 125 && cur_page == 1, "R3 row end", int'(cur_col), 125);
        accesses(1, "R3");
        chk(cur_col == 2 && cur_page == 2, "R3 carry", int'(cur_page), 2);
        accesses(124 * 5 - 1, "R3");
        chk(cur_col == 125 && cur_page == 6, "R5 last cell", int'(cur_col), 125);
        accesses(1, "R5");
        chk(cur_col == 2 && cur_page == 1, "R5 rect wrap", int'(cur_page), 1);

        // R4/R5: vertical with small window
        set_mode(1, "R4");
        set_windows(10, 12, 3, 5, "R6");
        accesses(3, "R4");
        chk(cur_col == 11 && cur_page == 3, "R4 carry", int'(cur_col), 11);
        accesses(6, "R5");
        chk(cur_col == 10 && cur_page == 3, "R5 vert wrap", int'(cur_col), 10);

        // R9: reserved code keeps vertical mode
        set_mode(3, "R9");
        accesses(1, "R9");
        chk(cur_page == 4 && cur_col == 10, "R9 still vertical", int'(cur_page), 4);

        // R11: idle
        for (int i = 0; i < 5; i++) run_cycle("R11");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            r = int'($urandom % 100);
            tg = (m_mode == 0) ? "R3" : (m_mode == 1) ? "R4" : "R2";
            if (r < 60) acc = 1;
            else if (r < 65) begin mode_set = 1; mode_code = 2'($urandom); tg = "R9"; end
            else if (r < 70) begin
                col_win_load = 1; col_lo_in = 7'($urandom); col_hi_in = 7'($urandom); tg = "R6";
            end else if (r < 75) begin
                page_win_load = 1; page_lo_in = 3'($urandom); page_hi_in = 3'($urandom); tg = "R6";
            end else if (r < 80) begin
                page_sel_load = 1; page_sel_in = 3'($urandom); tg = "R7";
            end else if (r < 85) begin
                col_nlo_load = 1'($urandom); col_nhi_load = 1'($urandom); nib_in = 4'($urandom); tg = "R7";
            end else if (r < 92) begin
                acc = 1; page_sel_load = 1'($urandom); col_nlo_load = 1'($urandom);
                page_sel_in = 3'($urandom); nib_in = 4'($urandom); tg = "R10";
            end else tg = "R11";
            run_cycle(tg);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule